// File: doc/BRIEF.md
# DMA Linked-List Descriptor Loader

This block sits beside one DMA channel and turns a single transfer into a chain of transfers. Software programs the channel's eight registers, then sets the enable bit of the control word. When the transfer engine reports that the current block is done, the loader looks at the channel's link pointer. A null pointer ends the chain and raises a one-cycle terminal-count pulse. A non-null pointer starts a fetch. The loader reads an eight-word descriptor from memory through a word-read port, one word at a time, and then replaces all eight registers in one cycle. After that it re-enables the channel for the next block.

The eight words of a descriptor use the same order as the channel registers: control, block size, source address low and high, destination address low and high, link pointer low and high. Each block therefore brings its own control word, so its address modes may differ from the previous block. A read error during a fetch stops the chain and sets a sticky error flag. An abort cancels a running block or an outstanding fetch and leaves the channel disabled.

Top module: `dma_chain_loader`

## Requirements
- R1: After a synchronous reset the channel is inactive, all eight registers read zero, and tc_pulse, fetch_err and mem_rd_req are low.
- R2: A write to byte address 0x40 + 0x20*CH_ID + 4*k with the two low address bits zero stores cfg_wdata into word k on the next clock. The words are k=0 control, 1 size, 2 source low, 3 source high, 4 destination low, 5 destination high, 6 link low, 7 link high, and ch_regs carries word k at bits [32k+31:32k]. A write to any other address changes nothing.
- R3: Writing word 0 with bit 0 set while the channel is idle makes ch_active high from the next cycle. Writing word 0 with bit 0 clear does not start the channel. Register writes are ignored while the channel is active or fetching.
- R4: A done pulse while active with a null link pointer (bits 63:6 of {link high, link low} all zero) drops ch_active and raises tc_pulse for exactly one cycle on the next cycle, with no memory read.
- R5: A done pulse while active with a non-null link pointer drops ch_active and then issues eight reads in order at address {link[ADDR_W-1:6], 6'b0} + 4*k for k = 0..7. Each request stays high with a stable address until mem_rd_valid.
- R6: The registers do not change during a fetch. They all take the eight fetched words in the cycle after the eighth good response, and ch_active returns high in that same cycle.
- R7: tc_pulse is raised only after the final block of a chain. A block that is followed by a descriptor fetch gives no pulse.
- R8: A response with mem_rd_err during a fetch ends the chain. From the next cycle fetch_err is high, the channel is inactive with no request, and the registers are unchanged. fetch_err clears when the channel is next started.
- R9: abort_req while active or fetching leaves the channel inactive with mem_rd_req low on the next cycle. It gives no terminal-count pulse and leaves the registers unchanged. abort_req takes priority over done and over a read response in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | REG_AW | Register byte address |
| cfg_wdata | input | 32 | Register write data |
| xfer_done | input | 1 | Current block finished (from transfer engine) |
| abort_req | input | 1 | Stop the channel and cancel any fetch |
| mem_rd_req | output | 1 | Descriptor word read request, held until valid |
| mem_rd_addr | output | ADDR_W | Byte address of the descriptor word |
| mem_rd_valid | input | 1 | Read response for the current request |
| mem_rd_err | input | 1 | Response carries a bus error |
| mem_rd_data | input | 32 | Read data |
| ch_regs | output | 256 | The eight channel registers, word k at bits [32k+31:32k] |
| ch_active | output | 1 | Channel enabled and running a block |
| tc_pulse | output | 1 | One-cycle end-of-chain event |
| fetch_err | output | 1 | Sticky descriptor fetch error |

## Verification
The bench runs a three-block chain whose last link pointer is non-zero only in its low six bits. A loader that tested the full pointer for null would then fetch again from address zero. A loader that pulsed terminal count on every block would be caught by the pulse count. Writes made while the channel is running must bounce off, and a design that updated registers word by word during a fetch would show torn contents on the cycle-by-cycle comparison. An error response on a middle descriptor word, and an abort while a slow read is pending, must both leave the previous block's registers intact and the request line down. A design that let either one through would reload a half-built descriptor or keep requesting.

// File: rtl/dma_ll_pkg.sv
package dma_ll_pkg;
    localparam int WORD_W      = 32;
    localparam int N_WORDS     = 8;
    localparam int IDX_W       = $clog2(N_WORDS);
    localparam int ALIGN_LG    = 6;
    localparam int IDX_CTRL    = 0;
    localparam int IDX_LINK_LO = 6;
    localparam int IDX_LINK_HI = 7;

    typedef logic [WORD_W-1:0]               word_t;
    typedef logic [N_WORDS-1:0][WORD_W-1:0]  desc_t;
    typedef logic [2*WORD_W-1:0]             link_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FETCH = 2'd2
    } seq_state_e;

    // Pointer bits below the alignment boundary carry no meaning.
    function automatic logic link_is_null(input link_t link);
        return (link >> ALIGN_LG) == '0;
    endfunction
endpackage

// File: rtl/dma_ll_regfile.sv
module dma_ll_regfile
    import dma_ll_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             sw_we,
    input  logic [IDX_W-1:0] sw_idx,
    input  word_t            sw_data,
    input  logic             ld_en,
    input  desc_t            ld_words,
    output desc_t            regs
);
    word_t regs_q [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                regs_q[g] <= '0;
            end else if (ld_en) begin
                regs_q[g] <= ld_words[g];
            end else if (sw_we && sw_idx == IDX_W'(g)) begin
                regs_q[g] <= sw_data;
            end
        end
        assign regs[g] = regs_q[g];
    end
endmodule

// File: rtl/dma_ll_seq.sv
module dma_ll_seq
    import dma_ll_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              done,
    input  logic              abort,
    input  link_t             link,
    output logic              rd_req,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic              rd_valid,
    input  logic              rd_err,
    input  word_t             rd_data,
    output logic              ld_en,
    output desc_t             ld_words,
    output logic              idle,
    output logic              active,
    output logic              tc,
    output logic              err
);
    seq_state_e                    st_q;
    logic [IDX_W-1:0]              idx_q;
    logic [N_WORDS-2:0][WORD_W-1:0] shadow_q;
    logic                          tc_q;
    logic                          err_q;
    logic                          beat_ok;
    logic                          last_beat;

    assign idle      = (st_q == ST_IDLE);
    assign active    = (st_q == ST_RUN);
    assign rd_req    = (st_q == ST_FETCH);
    assign rd_addr   = {link[ADDR_W-1:ALIGN_LG], {(ALIGN_LG-IDX_W-2){1'b0}}, idx_q, 2'b00};
    assign beat_ok   = rd_req && rd_valid && !rd_err && !abort;
    assign last_beat = (idx_q == IDX_W'(N_WORDS-1));
    assign ld_en     = beat_ok && last_beat;
    assign ld_words  = {rd_data, shadow_q};
    assign tc        = tc_q;
    assign err       = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            idx_q <= '0;
            tc_q  <= 1'b0;
            err_q <= 1'b0;
        end else begin
            tc_q <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start) begin
                        st_q  <= ST_RUN;
                        err_q <= 1'b0;
                    end
                end
                ST_RUN: begin
                    if (abort) begin
                        st_q <= ST_IDLE;
                    end else if (done) begin
                        if (link_is_null(link)) begin
                            st_q <= ST_IDLE;
                            tc_q <= 1'b1;
                        end else begin
                            st_q  <= ST_FETCH;
                            idx_q <= '0;
                        end
                    end
                end
                ST_FETCH: begin
                    if (abort) begin
                        st_q <= ST_IDLE;
                    end else if (rd_valid) begin
                        if (rd_err) begin
                            st_q  <= ST_IDLE;
                            err_q <= 1'b1;
                        end else begin
                            idx_q <= idx_q + 1'b1;
                            if (last_beat) st_q <= ST_RUN;
                        end
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    for (genvar g = 0; g < N_WORDS-1; g++) begin : g_shadow
        always_ff @(posedge clk) begin
            if (rst) begin
                shadow_q[g] <= '0;
            end else if (beat_ok && idx_q == IDX_W'(g)) begin
                shadow_q[g] <= rd_data;
            end
        end
    end

    // R5
    rd_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_valid && !abort) |=> (rd_req && $stable(rd_addr)));

    // R8
    fetch_err_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && rd_valid && rd_err && !abort) |=> (err && idle && !rd_req));

    // R9
    abort_stop_chk: assert property (@(posedge clk) disable iff (rst)
        (abort && !idle) |=> (idle && !rd_req && !tc));

    // R7
    tc_single_chk: assert property (@(posedge clk) disable iff (rst)
        tc |=> !tc);
endmodule

// File: rtl/dma_chain_loader.sv
module dma_chain_loader
    import dma_ll_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int REG_AW = 8,
    parameter int CH_ID  = 0
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cfg_we,
    input  logic [REG_AW-1:0]     cfg_addr,
    input  logic [WORD_W-1:0]     cfg_wdata,
    input  logic                  xfer_done,
    input  logic                  abort_req,
    output logic                  mem_rd_req,
    output logic [ADDR_W-1:0]     mem_rd_addr,
    input  logic                  mem_rd_valid,
    input  logic                  mem_rd_err,
    input  logic [WORD_W-1:0]     mem_rd_data,
    output logic [N_WORDS*WORD_W-1:0] ch_regs,
    output logic                  ch_active,
    output logic                  tc_pulse,
    output logic                  fetch_err
);
    localparam int WIN_LG = IDX_W + 2;
    localparam logic [REG_AW-1:0] WIN_BASE = REG_AW'('h40 + 'h20 * CH_ID);

    desc_t            regs;
    desc_t            ld_words;
    logic             ld_en;
    logic             seq_idle;
    logic             cfg_hit;
    logic [IDX_W-1:0] cfg_idx;
    logic             start;

    assign cfg_idx = cfg_addr[WIN_LG-1:2];
    assign cfg_hit = cfg_we
                  && (cfg_addr[REG_AW-1:WIN_LG] == WIN_BASE[REG_AW-1:WIN_LG])
                  && (cfg_addr[1:0] == 2'b00);
    assign start   = cfg_hit && seq_idle && (cfg_idx == IDX_W'(IDX_CTRL)) && cfg_wdata[0];

    dma_ll_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .sw_we    (cfg_hit && seq_idle),
        .sw_idx   (cfg_idx),
        .sw_data  (cfg_wdata),
        .ld_en    (ld_en),
        .ld_words (ld_words),
        .regs     (regs)
    );

    dma_ll_seq #(.ADDR_W(ADDR_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .done     (xfer_done),
        .abort    (abort_req),
        .link     ({regs[IDX_LINK_HI], regs[IDX_LINK_LO]}),
        .rd_req   (mem_rd_req),
        .rd_addr  (mem_rd_addr),
        .rd_valid (mem_rd_valid),
        .rd_err   (mem_rd_err),
        .rd_data  (mem_rd_data),
        .ld_en    (ld_en),
        .ld_words (ld_words),
        .idle     (seq_idle),
        .active   (ch_active),
        .tc       (tc_pulse),
        .err      (fetch_err)
    );

    assign ch_regs = regs;

    // R6
    fetch_regs_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_rd_req && !ld_en) |=> $stable(regs));
endmodule

// File: tb/dma_chain_loader_tb.sv
module dma_chain_loader_tb;
    localparam int BASE = 'h60;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cfg_we = 1'b0;
    logic [7:0]   cfg_addr = '0;
    logic [31:0]  cfg_wdata = '0;
    logic         xfer_done = 1'b0;
    logic         abort_req = 1'b0;
    logic         mem_rd_req;
    logic [31:0]  mem_rd_addr;
    logic         mem_rd_valid = 1'b0;
    logic         mem_rd_err = 1'b0;
    logic [31:0]  mem_rd_data = '0;
    logic [255:0] ch_regs;
    logic         ch_active;
    logic         tc_pulse;
    logic         fetch_err;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int tc_cnt = 0;
    int beat_cnt = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    dma_chain_loader #(.ADDR_W(32), .REG_AW(8), .CH_ID(1)) u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .xfer_done(xfer_done), .abort_req(abort_req),
        .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_err(mem_rd_err), .mem_rd_data(mem_rd_data),
        .ch_regs(ch_regs), .ch_active(ch_active), .tc_pulse(tc_pulse), .fetch_err(fetch_err)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural memory with programmable latency and one error word
    logic [31:0] mem [0:255];
    int lat = 2;
    int err_word = -1;
    int wait_cnt = 0;
    always @(posedge clk) begin
        if (rst) begin
            mem_rd_valid <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_rd_valid) begin
            mem_rd_valid <= 1'b0;
            wait_cnt <= 0;
        end else if (mem_rd_req) begin
            if (wait_cnt >= lat) begin
                mem_rd_valid <= 1'b1;
                mem_rd_data  <= mem[mem_rd_addr[9:2]];
                mem_rd_err   <= (int'(mem_rd_addr[9:2]) == err_word);
                wait_cnt <= 0;
            end else begin
                wait_cnt <= wait_cnt + 1;
            end
        end else begin
            wait_cnt <= 0;
        end
    end

    // reference model: 0 idle, 1 running, 2 fetching
    int          m_st = 0;
    int          m_idx = 0;
    logic [31:0] m_regs [8];
    logic [31:0] m_buf [8];
    bit          m_tc = 0;
    bit          m_err = 0;

    function automatic logic [63:0] m_link();
        return {m_regs[7], m_regs[6]} & ~64'h3f;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_idx = 0; m_tc = 0; m_err = 0;
            for (int k = 0; k < 8; k++) m_regs[k] = '0;
        end else begin
            m_tc = 0;
            if (m_st == 0) begin
                if (cfg_we && cfg_addr[7:5] == 3'd3 && cfg_addr[1:0] == 2'b00) begin
                    m_regs[cfg_addr[4:2]] = cfg_wdata;
                    if (cfg_addr[4:2] == 3'd0 && cfg_wdata[0]) begin
                        m_st = 1; m_err = 0;
                    end
                end
            end else if (m_st == 1) begin
                if (abort_req) m_st = 0;
                else if (xfer_done) begin
                    if (m_link() == 64'd0) begin m_st = 0; m_tc = 1; end
                    else begin m_st = 2; m_idx = 0; end
                end
            end else begin
                if (abort_req) m_st = 0;
                else if (mem_rd_valid) begin
                    if (mem_rd_err) begin m_st = 0; m_err = 1; end
                    else begin
                        m_buf[m_idx] = mem_rd_data;
                        if (m_idx == 7) begin
                            for (int k = 0; k < 8; k++) m_regs[k] = m_buf[k];
                            m_st = 1;
                        end
                        m_idx = (m_idx + 1) % 8;
                    end
                end
            end
        end
    end

    // cycle-by-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            for (int k = 0; k < 8; k++) chk("R6 register word", 64'(ch_regs[k*32 +: 32]), 64'(m_regs[k]));
            chk("R3 ch_active", 64'(ch_active), 64'(m_st == 1));
            chk("R7 tc_pulse", 64'(tc_pulse), 64'(m_tc));
            chk("R8 fetch_err", 64'(fetch_err), 64'(m_err));
            chk("R5 mem_rd_req", 64'(mem_rd_req), 64'(m_st == 2));
            if (m_st == 2) chk("R5 mem_rd_addr", 64'(mem_rd_addr), (m_link() | 64'(m_idx * 4)) & 64'hffff_ffff);
            if (tc_pulse) tc_cnt++;
            if (mem_rd_req && mem_rd_valid) beat_cnt++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            errors++;
            $display("FAIL watchdog actual=%0d cycles expected=below 50000", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic wr(input int addr, input logic [31:0] data);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 8'(addr); cfg_wdata = data;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic prog(input logic [31:0] ctrl, input logic [31:0] size, input logic [31:0] link);
        wr(BASE + 4, size);
        wr(BASE + 8, 32'h0000_1000);
        wr(BASE + 12, 32'h0);
        wr(BASE + 16, 32'h0000_2000);
        wr(BASE + 20, 32'h0);
        wr(BASE + 24, link);
        wr(BASE + 28, 32'h0);
        wr(BASE, ctrl);
    endtask

    task automatic pulse_done();
        @(negedge clk); xfer_done = 1'b1;
        @(negedge clk); xfer_done = 1'b0;
    endtask

    task automatic pulse_abort();
        @(negedge clk); abort_req = 1'b1;
        @(negedge clk); abort_req = 1'b0;
    endtask

    task automatic wait_active();
        for (int i = 0; i < 200 && !ch_active; i++) @(negedge clk);
    endtask

    task automatic put_desc(input int byte_addr, input logic [31:0] ctrl, input logic [31:0] size,
                            input logic [31:0] src, input logic [31:0] dst, input logic [31:0] link);
        int w;
        w = byte_addr / 4;
        mem[w] = ctrl; mem[w+1] = size; mem[w+2] = src; mem[w+3] = 32'h0;
        mem[w+4] = dst; mem[w+5] = 32'h0; mem[w+6] = link; mem[w+7] = 32'h0;
    endtask

    function automatic logic [31:0] rw(input int k);
        return ch_regs[k*32 +: 32];
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) mem[i] = 32'(i) ^ 32'h5a5a_0000;
        put_desc('h40, 32'h0000_4011, 32'h20, 32'h0000_1100, 32'h0000_2200, 32'h80);
        put_desc('h80, 32'h0000_8021, 32'h10, 32'h0000_3300, 32'h0000_4400, 32'h15);
        put_desc('hC0, 32'h0000_0001, 32'h44, 32'h0, 32'h0, 32'h0);
        put_desc('h100, 32'h0000_0001, 32'h55, 32'h0, 32'h0, 32'h0);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R1 reset regs", 64'(ch_regs == '0), 64'd1);
        chk("R1 reset active", 64'(ch_active), 64'd0);
        chk("R1 reset tc/err/req", 64'({tc_pulse, fetch_err, mem_rd_req}), 64'd0);

        // R2: other channel window and misaligned address are ignored
        wr('h44, 32'hAAAA_0001);
        wr(BASE + 5, 32'hBBBB_0002);
        chk("R2 foreign write word1", 64'(rw(1)), 64'd0);
        wr(BASE + 4, 32'h0000_0077);
        chk("R2 window write word1", 64'(rw(1)), 64'h77);

        // R3: ctrl write without enable bit does not start
        wr(BASE, 32'h0000_4010);
        @(negedge clk);
        chk("R3 no start without bit0", 64'(ch_active), 64'd0);

        // three-block chain
        tc_cnt = 0; beat_cnt = 0;
        prog(32'h0000_0005, 32'h0000_0030, 32'h40);
        chk("R3 started", 64'(ch_active), 64'd1);
        pulse_done();
        chk("R5 fetch begun", 64'(mem_rd_req), 64'd1);
        wait_active();
        chk("R6 block A ctrl", 64'(rw(0)), 64'h4011);
        chk("R6 block A src", 64'(rw(2)), 64'h1100);
        chk("R7 no tc mid chain", 64'(tc_cnt), 64'd0);
        wr(BASE + 4, 32'h0000_DEAD);
        chk("R3 write ignored while active", 64'(rw(1)), 64'h20);
        pulse_done();
        wait_active();
        chk("R6 block B ctrl", 64'(rw(0)), 64'h8021);
        chk("R6 block B link", 64'(rw(6)), 64'h15);
        pulse_done();
        repeat (4) @(negedge clk);
        chk("R7 one tc for chain", 64'(tc_cnt), 64'd1);
        chk("R4 junk low link bits end chain", 64'(mem_rd_req), 64'd0);
        chk("R5 sixteen beats", 64'(beat_cnt), 64'd16);

        // R8: error on a middle descriptor word
        lat = 0; err_word = ('hC0 / 4) + 3;
        prog(32'h0000_0001, 32'h0000_0007, 32'hC0);
        pulse_done();
        repeat (12) @(negedge clk);
        chk("R8 err set", 64'(fetch_err), 64'd1);
        chk("R8 inactive no req", 64'({ch_active, mem_rd_req}), 64'd0);
        chk("R8 regs kept", 64'(rw(1)), 64'h7);
        err_word = -1;

        // R4: single block, null link, error cleared on start
        tc_cnt = 0; beat_cnt = 0;
        prog(32'h0000_0001, 32'h0000_0009, 32'h0);
        chk("R8 err cleared on start", 64'(fetch_err), 64'd0);
        pulse_done();
        repeat (3) @(negedge clk);
        chk("R4 tc once", 64'(tc_cnt), 64'd1);
        chk("R4 no fetch", 64'(beat_cnt), 64'd0);
        chk("R4 inactive", 64'(ch_active), 64'd0);

        // R9: abort during a slow fetch, then during a running block
        lat = 6;
        prog(32'h0000_0001, 32'h0000_0033, 32'h100);
        pulse_done();
        repeat (2) @(negedge clk);
        chk("R5 request pending", 64'(mem_rd_req), 64'd1);
        pulse_abort();
        chk("R9 abort drops req", 64'({ch_active, mem_rd_req}), 64'd0);
        chk("R9 regs kept size", 64'(rw(1)), 64'h33);
        chk("R9 regs kept link", 64'(rw(6)), 64'h100);
        tc_cnt = 0;
        prog(32'h0000_0001, 32'h0000_0044, 32'h0);
        pulse_abort();
        pulse_done();
        repeat (3) @(negedge clk);
        chk("R9 abort in run", 64'(ch_active), 64'd0);
        chk("R9 no tc after abort", 64'(tc_cnt), 64'd0);

        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule